// File: doc/BRIEF.md
# Memory-Mapped Control Register Bank

This block is a bank of 32-bit control and status registers behind an AXI4-Lite slave port. Software reaches it through byte addresses. Every word-aligned offset maps to one of four access kinds: read-write, read-only, write-only, or unmapped. The hardware side sees the stored fields as plain output wires. It also supplies one live status word that software can read.

The map holds a global configuration word and a status word, followed by a repeated array of per-channel pairs. Each pair is a DMA read-address word and a channel setup word, with a stride of eight bytes.
- The global word carries a run enable and a two-bit direction code.
- A sanitised pin-mode output turns the reserved direction code into high impedance.
- The channel setup word is write-only. It carries a channel enable and a stream side-band tag, and it always reads back as zero.

The write side is run by a five-state machine: `W_IDLE`, `W_HAVE_ADDR`, `W_HAVE_DATA`, `W_COMMIT` and `W_RESP`.
- From `W_IDLE`: the address alone leads to `W_HAVE_ADDR`, the data alone leads to `W_HAVE_DATA`, and both together lead straight to `W_COMMIT`.
- `W_HAVE_ADDR` moves to `W_COMMIT` when the data arrives, and `W_HAVE_DATA` moves to `W_COMMIT` when the address arrives.
- `W_COMMIT` updates the store and always moves to `W_RESP`.
- `W_RESP` holds the response until it is accepted, then returns to `W_IDLE`.

The read side has two states, `R_IDLE` and `R_DATA`.
- An accepted read address moves `R_IDLE` to `R_DATA` and captures the word.
- `R_DATA` returns to `R_IDLE` once the data is taken.

Top module: `ctrl_regbank`

## Requirements
- R1: After reset the global word reads 0x3: `run_enable` is 1, `dir_code` is 1, `pin_mode` is 1, and every channel output is zero.
- R2: Offset 0x00 is read-write. Bit 0 is the run enable and bits 2:1 are the direction code. A read returns only these three bits, and all higher bits read 0.
- R3: The direction codes are: 0 receive, 1 high impedance, 2 drive. `pin_mode` equals `dir_code` for codes 0, 1 and 2, and is 1 for the reserved code 3.
- R4: Offset 0x04 is read-only and returns `status_word` as sampled when the read address is accepted. A write there gets an OKAY response and changes nothing.
- R5: For channel i, the word at 0x08+8i is read-write. Its 32-bit value appears on `ch_rd_addr[32i+31:32i]` and reads back unchanged.
- R6: For channel i, the word at 0x0C+8i is write-only.
  - Bit 0 drives `ch_enable[i]`.
  - Bits 8:1 drive `ch_tuser[8i+7:8i]`.
  - Reads of this word return 0 with an OKAY response.
- R7: Strobe bit k enables byte lane k (data bits 8k+7:8k). Lanes whose strobe bit is clear keep their old contents.
- R8: The write address and write data may arrive in either order, separated by any number of cycles. Each write produces exactly one response, and neither channel is accepted again until that response has been taken.
- R9: Any offset from 0x28 upward is unmapped.
  - Writes there get SLVERR (2) and change nothing.
  - Reads there get SLVERR with data 0.
  - Mapped offsets answer OKAY (0).
- R10: A raised `s_bvalid` or `s_rvalid` stays high, with a stable payload, until the matching ready is seen. No new read address is accepted while read data is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (0 OKAY, 2 SLVERR) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (0 OKAY, 2 SLVERR) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| status_word | input | 32 | Hardware-supplied status value |
| run_enable | output | 1 | Global run enable |
| dir_code | output | 2 | Stored direction code |
| pin_mode | output | 2 | Sanitised direction for pin control |
| ch_rd_addr | output | 32*NUM_CH | Per-channel DMA read addresses |
| ch_enable | output | NUM_CH | Per-channel enables |
| ch_tuser | output | TUSER_W*NUM_CH | Per-channel stream side-band tags |

## Verification
The bench sweeps all eight values of the global word with junk in the upper bits. A bank that packed fields wrongly would read back junk, and one that forgot the reserved direction code would drive `pin_mode` to 3.

It writes all sixteen strobe patterns to one address word. A lane-decode slip would corrupt bytes that should have been left alone.

It also covers the following cases, each of which exposes a specific fault:
- Channel setup words are written per channel and then read back. A wrong stride or array index shows up in the wrong channel's outputs, and a missing read mask returns the stored setup value instead of 0.
- Writes arrive with the address first and with the data first. A machine that assumes arrival order would hang or commit stale data.
- Unmapped and read-only offsets are hit. A loose decoder would alias onto a real register, which shows as a changed output or a wrong response code.
- A read is held back by a low ready. A port that dropped or replaced pending data would show a changed data word or a new read address being accepted.

// File: rtl/ctrl_regbank_pkg.sv
package ctrl_regbank_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned STRB_W = DATA_W / 8;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_RO,
        ACC_WO,
        ACC_RW
    } acc_e;

    typedef enum logic [2:0] {
        W_IDLE,
        W_HAVE_ADDR,
        W_HAVE_DATA,
        W_COMMIT,
        W_RESP
    } wr_state_e;

    typedef enum logic {
        R_IDLE,
        R_DATA
    } rd_state_e;

    // Access kind of a 32-bit word, by word index.
    function automatic acc_e word_access(input int unsigned idx, input int unsigned num_ch);
        if (idx == 0)
            return ACC_RW;
        else if (idx == 1)
            return ACC_RO;
        else if (idx < 2 + 2 * num_ch)
            return (((idx - 2) % 2) == 0) ? ACC_RW : ACC_WO;
        else
            return ACC_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [STRB_W-1:0] strb);
        logic [DATA_W-1:0] m;
        for (int k = 0; k < STRB_W; k++)
            m[8*k +: 8] = {8{strb[k]}};
        return m;
    endfunction

endpackage

// File: rtl/regbank_wr_fsm.sv
module regbank_wr_fsm
    import ctrl_regbank_pkg::*;
#(
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  aw_idx,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [DATA_W-1:0] commit_data,
    output logic [STRB_W-1:0] commit_strb
);

    wr_state_e state_q, state_d;
    logic      aw_fire, w_fire;
    logic [1:0] resp_q;

    assign aw_fire = awvalid && awready;
    assign w_fire  = wvalid && wready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= W_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: begin
                if (aw_fire && w_fire)
                    state_d = W_COMMIT;
                else if (aw_fire)
                    state_d = W_HAVE_ADDR;
                else if (w_fire)
                    state_d = W_HAVE_DATA;
            end
            W_HAVE_ADDR: if (w_fire)  state_d = W_COMMIT;
            W_HAVE_DATA: if (aw_fire) state_d = W_COMMIT;
            W_COMMIT:                 state_d = W_RESP;
            W_RESP:      if (bready)  state_d = W_IDLE;
            default:                  state_d = W_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        bvalid  = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            W_IDLE:      begin awready = 1'b1; wready = 1'b1; end
            W_HAVE_ADDR: wready  = 1'b1;
            W_HAVE_DATA: awready = 1'b1;
            W_COMMIT:    commit  = 1'b1;
            W_RESP:      bvalid  = 1'b1;
            default:     ;
        endcase
    end

    // Capture of address, data and response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_idx  <= '0;
            commit_data <= '0;
            commit_strb <= '0;
            resp_q      <= RESP_OKAY;
        end else begin
            if (aw_fire)
                commit_idx <= aw_idx;
            if (w_fire) begin
                commit_data <= wdata;
                commit_strb <= wstrb;
            end
            if (state_q == W_COMMIT)
                resp_q <= (word_access(int'(commit_idx), NUM_CH) == ACC_NONE) ? RESP_SLVERR : RESP_OKAY;
        end
    end

    assign bresp = resp_q;

    p_bvalid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid && $stable(bresp));

    p_one_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> !awready && !wready);

endmodule

// File: rtl/regbank_rd_fsm.sv
module regbank_rd_fsm
    import ctrl_regbank_pkg::*;
#(
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ar_idx,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic [DATA_W-1:0] lookup_word
);

    rd_state_e state_q, state_d;
    logic      ar_fire;

    assign ar_fire = arvalid && arready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= R_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE: if (ar_fire) state_d = R_DATA;
            R_DATA: if (rready)  state_d = R_IDLE;
            default:             state_d = R_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (state_q)
            R_IDLE:  arready = 1'b1;
            R_DATA:  rvalid  = 1'b1;
            default: ;
        endcase
    end

    // Capture of the read word and its response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            rresp <= RESP_OKAY;
        end else if (ar_fire) begin
            rdata <= lookup_word;
            rresp <= (word_access(int'(ar_idx), NUM_CH) == ACC_NONE) ? RESP_SLVERR : RESP_OKAY;
        end
    end

    p_rvalid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp));

    p_no_ar_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && rresp == RESP_SLVERR |-> rdata == '0);

endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import ctrl_regbank_pkg::*;
#(
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned TUSER_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [STRB_W-1:0]         wr_strb,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [DATA_W-1:0]         rd_word,
    input  logic [DATA_W-1:0]         status_word,
    output logic                      run_enable,
    output logic [1:0]                dir_code,
    output logic [DATA_W*NUM_CH-1:0]  ch_rd_addr,
    output logic [NUM_CH-1:0]         ch_enable,
    output logic [TUSER_W*NUM_CH-1:0] ch_tuser
);

    localparam int unsigned GCFG_W  = 3;
    localparam int unsigned CHCFG_W = TUSER_W + 1;
    localparam logic [GCFG_W-1:0] GCFG_RESET = 3'b011;

    logic [DATA_W-1:0] wmask;
    logic [GCFG_W-1:0] gcfg_q;

    assign wmask = lane_mask(wr_strb);

    // Global configuration word
    always_ff @(posedge clk) begin
        if (!rst_n)
            gcfg_q <= GCFG_RESET;
        else if (wr_en && wr_idx == IDX_W'(0))
            gcfg_q <= (gcfg_q & ~wmask[GCFG_W-1:0]) | (wr_data[GCFG_W-1:0] & wmask[GCFG_W-1:0]);
    end

    assign run_enable = gcfg_q[0];
    assign dir_code   = gcfg_q[2:1];

    // Channel array: address word at 2+2i, setup word at 3+2i
    logic [DATA_W-1:0]  ch_addr_q [NUM_CH];
    logic [CHCFG_W-1:0] ch_cfg_q  [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [IDX_W-1:0] ADDR_IDX = IDX_W'(2 + 2 * i);
        localparam logic [IDX_W-1:0] CFG_IDX  = IDX_W'(3 + 2 * i);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_addr_q[i] <= '0;
                ch_cfg_q[i]  <= '0;
            end else if (wr_en) begin
                if (wr_idx == ADDR_IDX)
                    ch_addr_q[i] <= (ch_addr_q[i] & ~wmask) | (wr_data & wmask);
                if (wr_idx == CFG_IDX)
                    ch_cfg_q[i] <= (ch_cfg_q[i] & ~wmask[CHCFG_W-1:0])
                                 | (wr_data[CHCFG_W-1:0] & wmask[CHCFG_W-1:0]);
            end
        end

        assign ch_rd_addr[DATA_W*i +: DATA_W]   = ch_addr_q[i];
        assign ch_enable[i]                     = ch_cfg_q[i][0];
        assign ch_tuser[TUSER_W*i +: TUSER_W]   = ch_cfg_q[i][CHCFG_W-1:1];
    end

    // Read lookup, masked by access kind
    always_comb begin
        rd_word = '0;
        unique case (word_access(int'(rd_idx), NUM_CH))
            ACC_RO: rd_word = status_word;
            ACC_RW: begin
                if (rd_idx == IDX_W'(0))
                    rd_word = DATA_W'(gcfg_q);
                else
                    rd_word = ch_addr_q[(int'(rd_idx) - 2) / 2];
            end
            default: rd_word = '0;
        endcase
    end

    p_gcfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(gcfg_q));

    p_ro_untouched_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx == IDX_W'(1) |=> $stable(gcfg_q) && $stable(ch_enable));

endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
    import ctrl_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned NUM_CH        = 4,
    parameter int unsigned TUSER_W       = 8,
    parameter int unsigned STREAM_DATA_W = 64,
    parameter int unsigned SYS_CLK_HZ    = 156250000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         s_awaddr,
    input  logic                      s_awvalid,
    output logic                      s_awready,
    input  logic [31:0]               s_wdata,
    input  logic [3:0]                s_wstrb,
    input  logic                      s_wvalid,
    output logic                      s_wready,
    output logic [1:0]                s_bresp,
    output logic                      s_bvalid,
    input  logic                      s_bready,
    input  logic [ADDR_W-1:0]         s_araddr,
    input  logic                      s_arvalid,
    output logic                      s_arready,
    output logic [31:0]               s_rdata,
    output logic [1:0]                s_rresp,
    output logic                      s_rvalid,
    input  logic                      s_rready,
    input  logic [31:0]               status_word,
    output logic                      run_enable,
    output logic [1:0]                dir_code,
    output logic [1:0]                pin_mode,
    output logic [32*NUM_CH-1:0]      ch_rd_addr,
    output logic [NUM_CH-1:0]         ch_enable,
    output logic [TUSER_W*NUM_CH-1:0] ch_tuser
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic              commit;
    logic [IDX_W-1:0]  commit_idx;
    logic [DATA_W-1:0] commit_data;
    logic [STRB_W-1:0] commit_strb;
    logic [DATA_W-1:0] lookup_word;

    regbank_wr_fsm #(.IDX_W(IDX_W), .NUM_CH(NUM_CH)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .aw_idx      (s_awaddr[ADDR_W-1:2]),
        .awvalid     (s_awvalid),
        .awready     (s_awready),
        .wdata       (s_wdata),
        .wstrb       (s_wstrb),
        .wvalid      (s_wvalid),
        .wready      (s_wready),
        .bresp       (s_bresp),
        .bvalid      (s_bvalid),
        .bready      (s_bready),
        .commit      (commit),
        .commit_idx  (commit_idx),
        .commit_data (commit_data),
        .commit_strb (commit_strb)
    );

    regbank_rd_fsm #(.IDX_W(IDX_W), .NUM_CH(NUM_CH)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ar_idx      (s_araddr[ADDR_W-1:2]),
        .arvalid     (s_arvalid),
        .arready     (s_arready),
        .rdata       (s_rdata),
        .rresp       (s_rresp),
        .rvalid      (s_rvalid),
        .rready      (s_rready),
        .lookup_word (lookup_word)
    );

    regbank_store #(.IDX_W(IDX_W), .NUM_CH(NUM_CH), .TUSER_W(TUSER_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (commit),
        .wr_idx      (commit_idx),
        .wr_data     (commit_data),
        .wr_strb     (commit_strb),
        .rd_idx      (s_araddr[ADDR_W-1:2]),
        .rd_word     (lookup_word),
        .status_word (status_word),
        .run_enable  (run_enable),
        .dir_code    (dir_code),
        .ch_rd_addr  (ch_rd_addr),
        .ch_enable   (ch_enable),
        .ch_tuser    (ch_tuser)
    );

    // Reserved direction code 3 is treated as high impedance (1)
    assign pin_mode = (dir_code == 2'd3) ? 2'd1 : dir_code;

    p_pin_safe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mode != 2'd3);

endmodule

// File: tb/tb_ctrl_regbank.sv
module tb_ctrl_regbank;

    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  s_awaddr = '0, s_araddr = '0;
    logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
    logic        s_bready = 1'b1, s_rready = 1'b1;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic [31:0] status_word = '0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic        run_enable;
    logic [1:0]  dir_code, pin_mode;
    logic [32*NCH-1:0] ch_rd_addr;
    logic [NCH-1:0]    ch_enable;
    logic [8*NCH-1:0]  ch_tuser;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ctrl_regbank dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .status_word(status_word), .run_enable(run_enable), .dir_code(dir_code),
        .pin_mode(pin_mode), .ch_rd_addr(ch_rd_addr), .ch_enable(ch_enable),
        .ch_tuser(ch_tuser)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                             input int ad, input int wd, output logic [1:0] resp);
        bit ap = 1, wp = 1, af, wf;
        int n = 0;
        @(negedge clk);
        while (ap || wp) begin
            if (ap && n >= ad) begin s_awaddr = a; s_awvalid = 1'b1; end
            if (wp && n >= wd) begin s_wdata = d; s_wstrb = s; s_wvalid = 1'b1; end
            af = s_awvalid && s_awready;
            wf = s_wvalid && s_wready;
            @(negedge clk);
            n++;
            if (af) begin s_awvalid = 1'b0; ap = 0; end
            if (wf) begin s_wvalid = 1'b0; wp = 0; end
        end
        while (!s_bvalid) @(negedge clk);
        resp = s_bresp;
        @(negedge clk);
    endtask

    task automatic axi_read(input logic [7:0] a, input int hold,
                            output logic [31:0] d, output logic [1:0] resp);
        bit af = 0;
        @(negedge clk);
        s_araddr = a;
        s_arvalid = 1'b1;
        while (!af) begin
            af = s_arready;
            @(negedge clk);
        end
        s_arvalid = 1'b0;
        if (hold > 0) s_rready = 1'b0;
        while (!s_rvalid) @(negedge clk);
        for (int k = 0; k < hold; k++) begin
            chk("R10 rdata stable while stalled", s_rdata, d_first(k, s_rdata));
            chk("R10 rvalid held", {31'b0, s_rvalid}, 32'd1);
            chk("R10 no read accepted while pending", {31'b0, s_arready}, 32'd0);
            @(negedge clk);
        end
        s_rready = 1'b1;
        d = s_rdata;
        resp = s_rresp;
        @(negedge clk);
    endtask

    logic [31:0] first_seen;
    function automatic logic [31:0] d_first(input int k, input logic [31:0] cur);
        if (k == 0) first_seen = cur;
        return first_seen;
    endfunction

    logic [31:0] exp_addr [NCH];
    logic        exp_en   [NCH];
    logic [7:0]  exp_tu   [NCH];

    task automatic chk_channels(input string tag);
        for (int i = 0; i < NCH; i++) begin
            chk(tag, ch_rd_addr[32*i +: 32], exp_addr[i]);
            chk(tag, {31'b0, ch_enable[i]}, {31'b0, exp_en[i]});
            chk(tag, {24'b0, ch_tuser[8*i +: 8]}, {24'b0, exp_tu[i]});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] resp;
        logic [31:0] rd, d, m, e, cfg_exp;
        for (int i = 0; i < NCH; i++) begin exp_addr[i] = 0; exp_en[i] = 0; exp_tu[i] = 0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 run_enable", {31'b0, run_enable}, 32'd1);
        chk("R1 dir_code", {30'b0, dir_code}, 32'd1);
        chk("R1 pin_mode", {30'b0, pin_mode}, 32'd1);
        chk_channels("R1 channel reset");
        axi_read(8'h00, 0, rd, resp);
        chk("R1 global reads 0x3", rd, 32'h3);

        // R2/R3 sweep of the global word with junk upper bits
        for (int v = 0; v < 8; v++) begin
            logic [1:0] dv;
            dv = 2'(v >> 1);
            axi_write(8'h00, 32'hFFFF_FFF8 | 32'(v), 4'hF, 0, 0, resp);
            chk("R9 mapped write OKAY", {30'b0, resp}, 32'd0);
            chk("R2 run_enable", {31'b0, run_enable}, 32'(v & 1));
            chk("R2 dir_code", {30'b0, dir_code}, {30'b0, dv});
            chk("R3 pin_mode", {30'b0, pin_mode}, (dv == 2'd3) ? 32'd1 : {30'b0, dv});
            axi_read(8'h00, 0, rd, resp);
            chk("R2 readback masked", rd, 32'(v));
        end
        cfg_exp = 32'h7;

        // R8 ordering: address first, then data first
        axi_write(8'h00, 32'h4, 4'hF, 0, 4, resp);
        chk("R8 addr-first resp", {30'b0, resp}, 32'd0);
        axi_read(8'h00, 0, rd, resp);
        chk("R8 addr-first value", rd, 32'h4);
        axi_write(8'h00, 32'h3, 4'hF, 5, 0, resp);
        axi_read(8'h00, 0, rd, resp);
        chk("R8 data-first value", rd, 32'h3);
        cfg_exp = 32'h3;

        // R7 strobe: lane 0 clear leaves config unchanged
        axi_write(8'h00, 32'h0, 4'hE, 0, 0, resp);
        axi_read(8'h00, 0, rd, resp);
        chk("R7 cleared lane keeps global", rd, cfg_exp);

        // R4 status word
        status_word = 32'hC0DE_1234;
        axi_read(8'h04, 0, rd, resp);
        chk("R4 status read", rd, 32'hC0DE_1234);
        axi_write(8'h04, 32'h0, 4'hF, 0, 0, resp);
        chk("R4 write resp OKAY", {30'b0, resp}, 32'd0);
        status_word = 32'h0BAD_F00D;
        axi_read(8'h04, 0, rd, resp);
        chk("R4 status live", rd, 32'h0BAD_F00D);
        axi_read(8'h00, 0, rd, resp);
        chk("R4 write ignored", rd, cfg_exp);

        // R5 address words
        for (int i = 0; i < NCH; i++) begin
            d = 32'h1000_0000 * (i + 1) + 32'h00AB_CD00 + 32'(i);
            axi_write(8'(8 + 8 * i), d, 4'hF, 0, 0, resp);
            exp_addr[i] = d;
        end
        chk_channels("R5 address outputs");
        for (int i = 0; i < NCH; i++) begin
            axi_read(8'(8 + 8 * i), 0, rd, resp);
            chk("R5 address readback", rd, exp_addr[i]);
        end

        // R6 setup words, write-only
        for (int i = 0; i < NCH; i++) begin
            logic [7:0] tu;
            tu = 8'(8'h30 + 8'h41 * i);
            axi_write(8'(12 + 8 * i), {23'b0, tu, 1'(i % 2 == 0)}, 4'hF, 0, 0, resp);
            exp_en[i] = (i % 2 == 0);
            exp_tu[i] = tu;
            chk_channels("R6 setup outputs");
            axi_read(8'(12 + 8 * i), 0, rd, resp);
            chk("R6 write-only reads zero", rd, 32'h0);
            chk("R6 write-only resp OKAY", {30'b0, resp}, 32'd0);
        end

        // R7 strobe sweep on channel 2 address word
        e = exp_addr[2];
        for (int s = 0; s < 16; s++) begin
            d = {4{8'(s * 17)}} ^ 32'h5A00_C300;
            m = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
            axi_write(8'h18, d, 4'(s), 0, 0, resp);
            e = (e & ~m) | (d & m);
            axi_read(8'h18, 0, rd, resp);
            chk("R7 strobe lanes", rd, e);
        end
        exp_addr[2] = e;
        chk_channels("R7 other channels intact");

        // R9 unmapped offsets
        for (int k = 0; k < 3; k++) begin
            logic [7:0] ua;
            ua = (k == 0) ? 8'h28 : (k == 1) ? 8'h40 : 8'hFC;
            axi_write(ua, 32'hFFFF_FFFF, 4'hF, 0, 0, resp);
            chk("R9 write SLVERR", {30'b0, resp}, 32'd2);
            axi_read(ua, 0, rd, resp);
            chk("R9 read SLVERR", {30'b0, resp}, 32'd2);
            chk("R9 read zero", rd, 32'h0);
        end
        chk_channels("R9 nothing changed");
        axi_read(8'h00, 0, rd, resp);
        chk("R9 global unchanged", rd, cfg_exp);

        // R10 stalled read
        axi_read(8'h08, 3, rd, resp);
        chk("R10 stalled read value", rd, exp_addr[0]);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule